// File: doc/BRIEF.md
# Alternating Dual-Compare Timer / Modulator

This block is an 8-bit up-counter paired with two compare values, A and B, that it checks one after the other. Each compare value has its own action byte. The action byte chooses what a match does: clear the counter, request an interrupt, or flip the waveform output. With the counter cleared on both matches and the output flipped on both, the output is high for one programmed length and low for the other. The period can therefore stay fixed while the duty cycle moves, or the pulse and space widths can be set separately.

The counter advances on a count tick. The tick comes either from an internal enable input or from a chosen edge of an external pin, which is synchronised first. A control byte starts and stops the counter. The same byte sets the level the waveform output rests at while the counter is stopped, and enables an interrupt on external edges that arrive while the timer is idle. All events drive a single interrupt line. A sticky status byte tells software which event fired. Software reaches every register through a simple one-cycle write and read port.

Top module: `dcmp_timer`

## Requirements
- R1: After reset the count reads 0, `wave_o` and `irq_o` are low, and every register, including STATUS (address 6), reads 0.
- R2: While the run bit is 0, the count holds at 0 and `wave_o` follows the idle-level bit. The run bit is bit 0 of CTRL (address 0) and the idle-level bit is bit 1 of CTRL. Clearing the run bit brings both back to these values.
- R3: A compare value x (0 to 255) matches on the (x+1)th count tick after the counter is at 0.
- R4: After start, comparisons alternate, beginning with A (address 2), then B (address 3), then A again. With the clear and flip actions set on both, and the idle level low, `wave_o` is high for B+1 ticks and low for A+1 ticks.
- R5: The action byte for A is at address 4 and the action byte for B is at address 5. In each, bit 0 clears the counter, bit 1 enables the interrupt and bit 2 flips `wave_o`. Each byte acts only on a match of its own compare value.
- R6: Action bit 3 makes a compare value match only once per start. After that match, only the other compare value is checked, and the once-only value raises no further match flag.
- R7: CLKSEL (address 1) picks the count source. With bit 0 = 0 the counter counts cycles where `tick_i` is high. With bit 0 = 1 it counts edges of `ext_in_i` after a two-stage synchroniser, and `tick_i` is ignored. CLKSEL bit 1 picks the edge: 1 = falling, 0 = rising.
- R8: STATUS has three sticky flags: bit 1 is an A match, bit 2 is a B match and bit 3 is an external edge. A read of STATUS clears them. A flag event in the same cycle as that read survives the clear.
- R9: `irq_o` is high exactly when the edge flag is set, or when a match flag is set and its action byte has bit 1 set.
- R10: The edge flag is set only while CTRL bit 2 is set and the counter is stopped.
- R11: STATUS bit 0 shows the run state, and address 7 reads the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe, used to clear the status flags |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| tick_i | input | 1 | Internal count enable |
| ext_in_i | input | 1 | External count or interrupt pin, asynchronous |
| wave_o | output | 1 | Modulated waveform output |
| irq_o | output | 1 | Shared interrupt request |

## Verification
A STATUS read clearing the flags and a new compare match setting one can land in the same clock cycle. The bench provokes this by setting both compare values to 0 with a count tick on every cycle, so a match happens on every cycle, and then issuing two STATUS reads back to back. The second read must still show a match flag. That flag can only come from the match in the first read's cycle, so it shows that setting a flag wins over clearing it.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CLK   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ACTA  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_ACTB  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd7;

    // per-compare action byte, bit 3 down to bit 0
    typedef struct packed {
        logic once;
        logic flip;
        logic irq;
        logic clr;
    } act_mask_t;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } cmp_sel_e;

endpackage

// File: rtl/dcmp_edge_det.sv
module dcmp_edge_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic fall_i,
    output logic edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t st_q, st_d;
    logic     cur;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], async_i};
        cur       = st_q.sync[STAGES-1];
        st_d.prev = cur;
        edge_o    = fall_i ? (st_q.prev & ~cur) : (~st_q.prev & cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dcmp_core.sv
module dcmp_core
    import dcmp_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             idle_lvl_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  act_mask_t        act_a_i,
    input  act_mask_t        act_b_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wave_o,
    output logic             hit_a_o,
    output logic             hit_b_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cmp_sel_e         sel;
        logic             used_a;
        logic             used_b;
        logic             wave;
    } core_st_t;

    core_st_t         st_q, st_d;
    logic             live_a, live_b, cur_live, hit;
    logic [CNT_W-1:0] cur_cmp;
    act_mask_t        cur_act;

    always_comb begin
        st_d     = st_q;
        live_a   = !(act_a_i.once && st_q.used_a);
        live_b   = !(act_b_i.once && st_q.used_b);
        cur_cmp  = (st_q.sel == SEL_B) ? cmp_b_i : cmp_a_i;
        cur_act  = (st_q.sel == SEL_B) ? act_b_i : act_a_i;
        cur_live = (st_q.sel == SEL_B) ? live_b  : live_a;
        hit      = run_i && tick_i && cur_live && (st_q.cnt == cur_cmp);

        if (!run_i) begin
            st_d.cnt    = '0;
            st_d.sel    = SEL_A;
            st_d.used_a = 1'b0;
            st_d.used_b = 1'b0;
            st_d.wave   = idle_lvl_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (hit) begin
                if (cur_act.clr)  st_d.cnt  = '0;
                if (cur_act.flip) st_d.wave = ~st_q.wave;
                if (st_q.sel == SEL_A) begin
                    st_d.used_a = 1'b1;
                    st_d.sel    = live_b ? SEL_B : SEL_A;
                end else begin
                    st_d.used_b = 1'b1;
                    st_d.sel    = live_a ? SEL_A : SEL_B;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign wave_o  = st_q.wave;
    assign hit_a_o = hit && (st_q.sel == SEL_A);
    assign hit_b_o = hit && (st_q.sel == SEL_B);

endmodule

// File: rtl/dcmp_timer.sv
module dcmp_timer
    import dcmp_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    input  logic              tick_i,
    input  logic              ext_in_i,
    output logic              wave_o,
    output logic              irq_o
);

    localparam int unsigned DW = CNT_W;

    typedef struct packed {
        logic            run;
        logic            idle_lvl;
        logic            edge_en;
        logic            ext_sel;
        logic            fall_sel;
        logic [DW-1:0]   cmp_a;
        logic [DW-1:0]   cmp_b;
        act_mask_t       act_a;
        act_mask_t       act_b;
        logic            flg_a;
        logic            flg_b;
        logic            flg_edge;
    } regs_st_t;

    regs_st_t         regs_q, regs_d;
    logic             ext_edge_w, tick_w, hit_a_w, hit_b_w;
    logic             run_w, idle_w, flg_a_w, flg_b_w, flg_edge_w;
    logic [CNT_W-1:0] cnt_w;

    dcmp_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_in_i),
        .fall_i  (regs_q.fall_sel),
        .edge_o  (ext_edge_w)
    );

    assign tick_w = regs_q.ext_sel ? ext_edge_w : tick_i;

    dcmp_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (regs_q.run),
        .tick_i     (tick_w),
        .idle_lvl_i (regs_q.idle_lvl),
        .cmp_a_i    (regs_q.cmp_a),
        .cmp_b_i    (regs_q.cmp_b),
        .act_a_i    (regs_q.act_a),
        .act_b_i    (regs_q.act_b),
        .cnt_o      (cnt_w),
        .wave_o     (wave_o),
        .hit_a_o    (hit_a_w),
        .hit_b_o    (hit_b_w)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (addr_i)
                ADR_CTRL: begin
                    regs_d.run      = wdata_i[0];
                    regs_d.idle_lvl = wdata_i[1];
                    regs_d.edge_en  = wdata_i[2];
                end
                ADR_CLK: begin
                    regs_d.ext_sel  = wdata_i[0];
                    regs_d.fall_sel = wdata_i[1];
                end
                ADR_CMPA: regs_d.cmp_a = wdata_i;
                ADR_CMPB: regs_d.cmp_b = wdata_i;
                ADR_ACTA: regs_d.act_a = act_mask_t'(wdata_i[3:0]);
                ADR_ACTB: regs_d.act_b = act_mask_t'(wdata_i[3:0]);
                default: ;
            endcase
        end
        // clear on read first, so an event in the same cycle wins
        if (rd_en_i && addr_i == ADR_STAT) begin
            regs_d.flg_a    = 1'b0;
            regs_d.flg_b    = 1'b0;
            regs_d.flg_edge = 1'b0;
        end
        if (hit_a_w) regs_d.flg_a = 1'b1;
        if (hit_b_w) regs_d.flg_b = 1'b1;
        if (ext_edge_w && regs_q.edge_en && !regs_q.run) regs_d.flg_edge = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_CTRL:  begin
                rdata_o[0] = regs_q.run;
                rdata_o[1] = regs_q.idle_lvl;
                rdata_o[2] = regs_q.edge_en;
            end
            ADR_CLK:   begin
                rdata_o[0] = regs_q.ext_sel;
                rdata_o[1] = regs_q.fall_sel;
            end
            ADR_CMPA:  rdata_o = regs_q.cmp_a;
            ADR_CMPB:  rdata_o = regs_q.cmp_b;
            ADR_ACTA:  rdata_o[3:0] = regs_q.act_a;
            ADR_ACTB:  rdata_o[3:0] = regs_q.act_b;
            ADR_STAT:  begin
                rdata_o[0] = regs_q.run;
                rdata_o[1] = regs_q.flg_a;
                rdata_o[2] = regs_q.flg_b;
                rdata_o[3] = regs_q.flg_edge;
            end
            ADR_COUNT: rdata_o = cnt_w;
            default: ;
        endcase
    end

    assign irq_o = (regs_q.flg_a && regs_q.act_a.irq)
                 || (regs_q.flg_b && regs_q.act_b.irq)
                 || regs_q.flg_edge;

    assign run_w      = regs_q.run;
    assign idle_w     = regs_q.idle_lvl;
    assign flg_a_w    = regs_q.flg_a;
    assign flg_b_w    = regs_q.flg_b;
    assign flg_edge_w = regs_q.flg_edge;

endmodule

// File: rtl/dcmp_timer_chk.sv
module dcmp_timer_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             idle,
    input logic             tick,
    input logic             ext_edge,
    input logic             hit_a,
    input logic             hit_b,
    input logic             flg_a,
    input logic             flg_b,
    input logic             flg_edge,
    input logic [CNT_W-1:0] cnt,
    input logic             wave,
    input logic             irq
);

    assert_stop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    assert_stop_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (wave == $past(idle)));

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt)));

    assert_flag_a_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flg_a);

    assert_flag_b_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> flg_b);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flg_a || flg_b || flg_edge));

    assert_edge_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge && run && !flg_edge) |=> !flg_edge);

endmodule

bind dcmp_timer dcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .idle     (idle_w),
    .tick     (tick_w),
    .ext_edge (ext_edge_w),
    .hit_a    (hit_a_w),
    .hit_b    (hit_b_w),
    .flg_a    (flg_a_w),
    .flg_b    (flg_b_w),
    .flg_edge (flg_edge_w),
    .cnt      (cnt_w),
    .wave     (wave_o),
    .irq      (irq_o)
);

// File: tb/dcmp_timer_tb.sv
`timescale 1ns/1ps
module dcmp_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_in = 1'b0;
    logic       wave, irq;
    logic       tick;
    int         div = 1;
    int         divcnt = 0;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (divcnt >= div - 1) divcnt = 0;
        else                   divcnt = divcnt + 1;
    end
    assign tick = (divcnt == 0);

    dcmp_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .rd_en_i  (rd_en),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .tick_i   (tick),
        .ext_in_i (ext_in),
        .wave_o   (wave),
        .irq_o    (irq)
    );

    function automatic int span(input int x, input int d);
        return (x + 1) * d;
    endfunction

    function automatic int joint(input int a, input int b, input int d);
        return ((a + 1) + (b + 1)) * d;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int n);
        logic w;
        w = wave;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (wave == w && n < 3000);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_in = 1'b1; idle(3);
            ext_in = 1'b0; idle(3);
        end
    endtask

    task automatic setup(input int a, input int b, input int ma, input int mb);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'(a));
        wr(3'd3, 8'(b));
        wr(3'd4, 8'(ma));
        wr(3'd5, 8'(mb));
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, s1, s2;
        int n;
        void'($urandom(32'h1234_5678));
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 wave", int'(wave), 0);
        check("R1 irq", int'(irq), 0);
        rd(3'd7, d); check("R1 count", int'(d), 0);
        rd(3'd6, d); check("R1 status", int'(d), 0);
        rd(3'd2, d); check("R1 cmp A", int'(d), 0);

        // R2 idle level drives the output while stopped
        wr(3'd0, 8'h02); idle(2);
        check("R2 idle high", int'(wave), 1);
        wr(3'd0, 8'h00); idle(2);
        check("R2 idle low", int'(wave), 0);

        // R4 / R3 / R7: random compare values and internal tick rates
        for (int it = 0; it < 16; it++) begin
            int a, b;
            a = int'($urandom_range(0, 20));
            b = int'($urandom_range(0, 20));
            div = int'($urandom_range(1, 3));
            setup(a, b, 5, 5);
            wr(3'd0, 8'h01);
            measure(n);
            measure(n); check("R4 high span (B+1)", n, span(b, div));
            measure(n); check("R4 low span (A+1)", n, span(a, div));
            wr(3'd0, 8'h00); idle(2);
        end
        div = 1;

        // R3 boundaries: 0 and 255
        setup(255, 0, 5, 5);
        wr(3'd0, 8'h01);
        measure(n);
        measure(n); check("R3 x=0 span", n, span(0, 1));
        measure(n); check("R3 x=255 span", n, span(255, 1));
        wr(3'd0, 8'h00); idle(2);

        // R5 flip only on A, clear on both
        setup(4, 6, 5, 1);
        wr(3'd0, 8'h01);
        measure(n);
        measure(n); check("R5 period", n, joint(4, 6, 1));
        measure(n); check("R5 period again", n, joint(4, 6, 1));
        wr(3'd0, 8'h00); idle(2);

        // R6 A once-only: A then B forever
        setup(10, 3, 13, 5);
        wr(3'd0, 8'h01);
        measure(n);
        measure(n); check("R6 B span", n, span(3, 1));
        measure(n); check("R6 B span again", n, span(3, 1));
        rd(3'd6, d);
        idle(20);
        rd(3'd6, d);
        check("R6 no second A flag", int'(d[1]), 0);
        check("R6 B flag", int'(d[2]), 1);
        wr(3'd0, 8'h00); idle(2);
        rd(3'd6, d);

        // R9 interrupt gating
        setup(2, 2, 3, 1);
        wr(3'd0, 8'h01); idle(10);
        check("R9 irq on A", int'(irq), 1);
        wr(3'd0, 8'h00); idle(2);
        rd(3'd6, d); idle(2);
        check("R8 irq cleared by read", int'(irq), 0);
        setup(2, 2, 1, 1);
        wr(3'd0, 8'h01); idle(10);
        check("R9 masked irq", int'(irq), 0);
        rd(3'd6, d);
        check("R9 flag without irq", int'(d[1]), 1);
        wr(3'd0, 8'h00); idle(2);
        rd(3'd6, d);

        // R8 set wins over clear, R11 running bit
        setup(0, 0, 1, 1);
        wr(3'd0, 8'h01); idle(3);
        rd(3'd6, s1);
        rd(3'd6, s2);
        check("R11 running bit", int'(s1[0]), 1);
        check("R8 set wins", int'(s2[2:1] != 2'b00), 1);
        wr(3'd0, 8'h00); idle(2);
        rd(3'd6, d);
        rd(3'd6, d);
        check("R8 cleared status, R11 stopped", int'(d), 0);

        // R10 edge interrupt only while stopped and enabled
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h04); idle(2);
        pulses(1); idle(4);
        check("R10 edge irq", int'(irq), 1);
        rd(3'd6, d);
        check("R10 edge flag", int'(d[3]), 1);
        wr(3'd0, 8'h00); idle(2);
        pulses(1); idle(4);
        rd(3'd6, d);
        check("R10 edge disabled", int'(d[3]), 0);
        setup(200, 200, 0, 0);
        wr(3'd0, 8'h05); idle(2);
        pulses(2); idle(4);
        rd(3'd6, d);
        check("R10 edge while running", int'(d[3]), 0);
        wr(3'd0, 8'h00); idle(2);

        // R7 external falling edges counted, tick_i ignored
        setup(200, 200, 0, 0);
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h01); idle(2);
        pulses(7); idle(6);
        rd(3'd7, d);
        check("R7 external count", int'(d), 7);
        wr(3'd0, 8'h00); idle(2);
        rd(3'd7, d);
        check("R2 count cleared on stop", int'(d), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule